// File: doc/BRIEF.md
# Sync-Gated Receive Byte Buffer

This block sits behind a demodulator and turns a serial bit stream into stored bytes. Each bit period the demodulator presents one bit on `bit_in` together with a one-cycle `bit_stb`. The block packs the bits into bytes and pushes each finished byte into a 16-entry byte FIFO. A host drains the FIFO through a valid/ready read port. Storing begins only once a start condition is met. In sync mode the start condition is an exact match of a 32-bit sync word against the most recent received bits. In host mode it is a level-sensitive start bit driven by the host.

Storing has no length limit. While the start condition holds, every completed byte goes into the FIFO, including noise bits that arrive after the far transmitter has stopped. Keeping the FIFO drained is the host's job.

When the FIFO fills, the host still has one byte time of grace: the pending byte in the shift register is kept until it completes. If it completes while the FIFO is still full and no read is taken in that cycle, the byte is dropped and a sticky overrun flag is raised. A one-cycle `flush` pulse empties the FIFO, clears overrun, discards any partial byte and re-arms the sync search.

Back-pressure rules on the read port:
- `out_valid` is high exactly when the FIFO is not empty.
- A byte leaves on a clock edge where both `out_valid` and `out_ready` are high.
- `out_data` shows the oldest byte while valid, and reads as zero while empty.
- The receive side cannot be stalled; any lack of room shows up as overrun.

Top module: `sync_rx_buffer`

## Requirements
- R1: Bits are shifted in most significant bit first. A byte is complete after exactly 8 bit strobes counted from the moment the start condition became active. The byte is in the FIFO by the second clock edge after its 8th strobe.
- R2: In sync mode (`mode_sel` = 0), nothing is stored until the last 32 received bits equal `sync_word` exactly. Only bytes whose bits all follow the matching bit are stored, so preamble and sync bits never enter the FIFO.
- R3: In host mode (`mode_sel` = 1), bytes are stored only while `host_start` is high. Dropping `host_start` discards a partial byte, and counting restarts from zero when it rises again.
- R4: There is no packet length limit. Once started, storing continues for every completed byte until `flush` or, in host mode, until `host_start` falls.
- R5: The FIFO holds 16 bytes. `fifo_full` is high as soon as the 16th byte is stored. `fifo_empty` is high when no byte is held. `out_valid` equals the inverse of `fifo_empty`, and bytes are read in arrival order.
- R6: `wr_pulse` is high for exactly one cycle, the cycle after each byte is written into the FIFO. It stays low for a byte that is discarded.
- R7: While the FIFO is full, a read taken before the next byte completes loses no data, and that next byte is then stored.
- R8: If a byte completes while the FIFO is full and no read occurs in that cycle, the byte is discarded and `overrun` goes high. `overrun` stays high until `flush`.
- R9: A byte that completes in the same cycle as a read from a full FIFO is stored, and `overrun` stays low.
- R10: While the FIFO is empty, `out_data` is zero. Asserting `out_ready` then has no effect on the FIFO.
- R11: A `flush` pulse empties the FIFO, clears `overrun` and re-arms the sync search. In sync mode, no byte is stored after a flush until a new sync match occurs.
- R12: After a match, the comparator is disarmed. A sync pattern appearing in the data is stored as ordinary data bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | Start condition select: 0 sync-word match, 1 host start bit |
| host_start | input | 1 | Host start level used in host mode |
| sync_word | input | 32 | Sync pattern; bit 31 is the first bit received |
| bit_in | input | 1 | Demodulated bit, sampled when `bit_stb` is high |
| bit_stb | input | 1 | One-cycle strobe marking a new bit |
| flush | input | 1 | Empties the FIFO, clears overrun, re-arms sync search |
| out_valid | output | 1 | FIFO holds at least one byte |
| out_ready | input | 1 | Host accepts the presented byte |
| out_data | output | 8 | Oldest stored byte, zero when empty |
| fifo_empty | output | 1 | No byte stored |
| fifo_full | output | 1 | 16 bytes stored |
| wr_pulse | output | 1 | One-cycle pulse after each stored byte |
| overrun | output | 1 | Sticky: a completed byte was dropped |

## Verification
The hardest case to reach is a byte completion that lands in exactly the same clock as a read from a full FIFO. The byte is written two edges after its eighth strobe, so the bench's byte-send task raises `out_ready` on the falling edge just before that write edge. This places the read exactly on the write cycle. The same task, run without the read, produces the discard and overrun case. The sync path is driven with a preamble followed by the sync word, and then with the sync word repeated inside the data to show that the disarmed comparator does not react.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef enum logic {
    START_SYNC = 1'b0,
    START_HOST = 1'b1
  } start_mode_e;
endpackage

// File: rtl/sync_rx_detect.sv
module sync_rx_detect #(
  parameter int SYNC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              bit_stb,
  input  logic              bit_in,
  input  logic [SYNC_W-1:0] sync_word,
  output logic              locked
);
  logic [SYNC_W-1:0] hist_q;
  logic [SYNC_W-1:0] window;
  logic              hit;

  assign window = {hist_q[SYNC_W-2:0], bit_in};
  // Search is live only while not yet locked.
  assign hit    = bit_stb && !locked && (window == sync_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      locked <= 1'b0;
    end else begin
      if (bit_stb) hist_q <= window;
      if (flush)     locked <= 1'b0;
      else if (hit)  locked <= 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_packer.sv
module sync_rx_packer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              active,
  input  logic              bit_stb,
  input  logic              bit_in,
  output logic              done,
  output logic [DATA_W-1:0] data
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] next_sr;

  assign next_sr = {sr_q[DATA_W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
      data  <= '0;
    end else begin
      done <= 1'b0;
      if (flush || !active) begin
        cnt_q <= '0;
      end else if (bit_stb) begin
        sr_q <= next_sr;
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          done  <= 1'b1;
          data  <= next_sr;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic              push_ok,
  output logic              empty,
  output logic              full,
  output logic [DATA_W-1:0] head
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     cnt_q;
  logic              pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign pop     = pop_req && !empty;
  assign push_ok = push && (!full || pop);
  assign head    = empty ? '0 : mem[rptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= bump(wptr_q);
      if (pop)     rptr_q <= bump(rptr_q);
      case ({push_ok, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sync_rx_buffer.sv
module sync_rx_buffer
  import sync_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int SYNC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              host_start,
  input  logic [SYNC_W-1:0] sync_word,
  input  logic              bit_in,
  input  logic              bit_stb,
  input  logic              flush,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              wr_pulse,
  output logic              overrun
);
  start_mode_e       mode;
  logic              locked;
  logic              active;
  logic              byte_done;
  logic [DATA_W-1:0] byte_data;
  logic              push_ok;

  assign mode   = start_mode_e'(mode_sel);
  assign active = (mode == START_HOST) ? host_start : locked;

  sync_rx_detect #(.SYNC_W(SYNC_W)) detect_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .bit_stb(bit_stb),
    .bit_in(bit_in), .sync_word(sync_word), .locked(locked)
  );

  sync_rx_packer #(.DATA_W(DATA_W)) packer_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .active(active),
    .bit_stb(bit_stb), .bit_in(bit_in), .done(byte_done), .data(byte_data)
  );

  sync_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(byte_done),
    .push_data(byte_data), .pop_req(out_ready), .push_ok(push_ok),
    .empty(fifo_empty), .full(fifo_full), .head(out_data)
  );

  assign out_valid = !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pulse <= 1'b0;
      overrun  <= 1'b0;
    end else if (flush) begin
      wr_pulse <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      wr_pulse <= push_ok;
      if (byte_done && !push_ok) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_buffer_chk.sv
module sync_rx_buffer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              fifo_empty,
  input logic              fifo_full,
  input logic              wr_pulse,
  input logic              overrun
);
  assert_valid_tracks_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == !fifo_empty);

  assert_never_full_and_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  assert_zero_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));

  assert_wr_pulse_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> !fifo_empty);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !flush) |=> overrun);

  assert_overrun_while_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> fifo_full);

  assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fifo_empty && !overrun && !wr_pulse));
endmodule

bind sync_rx_buffer sync_rx_buffer_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/sync_rx_buffer_tb_top.sv
`timescale 1ns/1ps
module sync_rx_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_sel = 1'b1;
  logic        host_start = 1'b0;
  logic [31:0] sync_word = 32'hA5C3_96E1;
  logic        bit_in = 1'b0;
  logic        bit_stb = 1'b0;
  logic        flush = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        fifo_empty, fifo_full, wr_pulse, overrun;

  int tests = 0;
  int fails = 0;
  logic [7:0] q[$];

  always #5 clk = ~clk;

  sync_rx_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .host_start(host_start),
    .sync_word(sync_word), .bit_in(bit_in), .bit_stb(bit_stb), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .wr_pulse(wr_pulse),
    .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_in = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
    @(negedge clk);
  endtask

  // Sends a byte MSB first; when pop is set, a read is placed on the write edge.
  task automatic send_byte(input logic [7:0] v, input bit pop, input logic [7:0] pexp);
    for (int i = 7; i > 0; i--) send_bit(v[i]);
    bit_in = v[0]; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
    if (pop) begin
      chk(out_valid && out_data == pexp, "R9 pop on write edge", out_data, pexp);
      out_ready = 1'b1;
    end
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic pop_check(input logic [7:0] exp, input string req);
    chk(out_valid && out_data == exp, req, {out_valid, out_data}, {1'b1, exp});
    out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic drain(input string req);
    while (q.size() > 0) pop_check(q.pop_front(), req);
    chk(fifo_empty, req, fifo_empty, 1);
  endtask

  task automatic do_flush();
    flush = 1'b1; @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fifo_empty && !fifo_full && !out_valid, "R5 reset flags", {fifo_empty, fifo_full, out_valid}, 3'b100);
    chk(!overrun && !wr_pulse, "R8 reset overrun", {overrun, wr_pulse}, 0);
    chk(out_data == 8'h00, "R10 zero data when empty", out_data, 0);

    // R10: read strobe on empty FIFO
    out_ready = 1'b1; @(negedge clk); @(negedge clk); out_ready = 1'b0;
    chk(fifo_empty && out_data == 0, "R10 empty read no effect", {fifo_empty, out_data}, 9'h100);

    // R1 R4 R5 R6: host mode sweep over all 256 byte values
    mode_sel = 1'b1; host_start = 1'b1;
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 16; k++) begin
        v = 8'((c * 16 + k) * 37 + 5);
        send_byte(v, 1'b0, 8'h00);
        q.push_back(v);
        chk(wr_pulse, "R6 write pulse", wr_pulse, 1);
        if (k == 14) chk(!fifo_full, "R5 not full at 15", fifo_full, 0);
      end
      @(negedge clk);
      chk(!wr_pulse, "R6 pulse one cycle", wr_pulse, 0);
      chk(fifo_full && !overrun, "R5 full at 16", {fifo_full, overrun}, 2'b10);
      drain("R1 msb-first data order");
    end

    // R3: partial byte discarded when start drops; nothing stored while low
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    host_start = 1'b0; @(negedge clk);
    send_byte(8'hF0, 1'b0, 8'h00);
    chk(fifo_empty && !wr_pulse, "R3 no store while start low", fifo_empty, 1);
    host_start = 1'b1; @(negedge clk);
    send_byte(8'h3C, 1'b0, 8'h00);
    q.push_back(8'h3C);
    drain("R3 restart counts from zero");

    // R7 R8 R9: full FIFO grace, simultaneous read/write, overrun
    for (int k = 0; k < 16; k++) begin
      send_byte(8'(8'h10 + k), 1'b0, 8'h00);
      q.push_back(8'(8'h10 + k));
    end
    chk(fifo_full, "R5 full before grace", fifo_full, 1);
    pop_check(q.pop_front(), "R7 read while full");
    send_byte(8'hA1, 1'b0, 8'h00); q.push_back(8'hA1);
    chk(fifo_full && !overrun && wr_pulse, "R7 grace byte stored", {fifo_full, overrun, wr_pulse}, 3'b101);
    send_byte(8'hA2, 1'b1, q.pop_front()); q.push_back(8'hA2);
    chk(fifo_full && !overrun && wr_pulse, "R9 simultaneous accepted", {fifo_full, overrun, wr_pulse}, 3'b101);
    send_byte(8'hA3, 1'b0, 8'h00);
    chk(overrun && !wr_pulse && fifo_full, "R8 overrun on full", {overrun, wr_pulse, fifo_full}, 3'b101);
    drain("R8 dropped byte absent");
    chk(overrun, "R8 overrun sticky", overrun, 1);
    do_flush();
    chk(!overrun && fifo_empty, "R11 flush clears overrun", {overrun, fifo_empty}, 2'b01);
    for (int k = 0; k < 3; k++) send_byte(8'h77, 1'b0, 8'h00);
    do_flush();
    chk(fifo_empty && out_data == 0, "R11 flush empties", {fifo_empty, out_data}, 9'h100);

    // R2 R4 R12: sync mode
    mode_sel = 1'b0; host_start = 1'b0;
    do_flush();
    send_byte(8'h55, 1'b0, 0); send_byte(8'h55, 1'b0, 0); send_byte(8'hAA, 1'b0, 0);
    chk(fifo_empty, "R2 preamble not stored", fifo_empty, 1);
    send_byte(8'hA5, 1'b0, 0); send_byte(8'hC3, 1'b0, 0);
    send_byte(8'h96, 1'b0, 0); send_byte(8'hE1, 1'b0, 0);
    chk(fifo_empty, "R2 sync not stored", fifo_empty, 1);
    send_byte(8'h11, 1'b0, 0); q.push_back(8'h11);
    send_byte(8'h22, 1'b0, 0); q.push_back(8'h22);
    send_byte(8'hA5, 1'b0, 0); q.push_back(8'hA5);
    send_byte(8'hC3, 1'b0, 0); q.push_back(8'hC3);
    send_byte(8'h96, 1'b0, 0); q.push_back(8'h96);
    send_byte(8'hE1, 1'b0, 0); q.push_back(8'hE1);
    send_byte(8'h33, 1'b0, 0); q.push_back(8'h33);
    drain("R12 sync inside data stored; R4 no length limit");

    // R11: re-armed search needs a new match
    do_flush();
    send_byte(8'h44, 1'b0, 0); send_byte(8'h5A, 1'b0, 0);
    chk(fifo_empty, "R11 no store before new match", fifo_empty, 1);
    send_byte(8'hA5, 1'b0, 0); send_byte(8'hC3, 1'b0, 0);
    send_byte(8'h96, 1'b0, 0); send_byte(8'hE1, 1'b0, 0);
    send_byte(8'h66, 1'b0, 0); q.push_back(8'h66);
    drain("R11 store after new match");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule